// File: doc/BRIEF.md
# Address Translation Fault Sequencer

This block decides, for one memory access at a time, how an effective address becomes a real address, or why it cannot. A request carries a 32-bit effective address, an access kind (instruction fetch, data load or data store), the privilege of the requester and the two translation-enable bits (one for fetches, one for data). The sequencer works through a fixed order of translation sources. Real mode comes first. Next is an external block matcher, then the segment register picked by the top address nibble. A direct-store segment is handled there and then. Otherwise a segment-level no-execute check runs, and last comes an external page-table walker followed by a permission check.

The block matcher and the table walker are separate units. Each sits behind a valid/ready request and a one-beat response. The sequencer ends every request with a one-cycle `done` pulse. That pulse comes with one of three results: a real address and its permission set, an instruction fault with a 32-bit error code, or a data fault with a fault address and a 32-bit status word. All result outputs keep their values until the next request completes.

Top module: `xlat_fault_seq`

## Requirements
- R1: When translation is off for the access side (`req_ien` low for a fetch, `req_den` low for a load or store), the result is ok with `real_addr` equal to the effective address and `res_prot` = 3'b111. Permission bits are [0] read, [1] write, [2] execute. Neither the block matcher nor the walker receives a request.
- R2: When translation is on, the block matcher is asked first. Access kind codes are 0 fetch, 1 load, 2 store, and 3 is treated as a load. If the matcher hits and its permission covers the access, the result is ok with `real_addr` = {`blk_rsp_rpn`, ea[11:0]}, `res_prot` = `blk_rsp_prot`, and no walk is started. A fetch needs execute, a store needs write and a load needs read.
- R3: A block hit that lacks the needed permission faults. A fetch gets instruction error code 0x08000000. A store gets data status 0x0A000000 and a load gets 0x08000000.
- R4: On a block miss, the segment register is entry ea[31:28] of `seg_file`, where entry i occupies bits [32*i+31:32*i]. The walker receives that entry's bits [23:0] as `walk_req_vsid` and ea[27:12] as `walk_req_pidx`.
- R5: In a segment with bit 31 set (direct store) whose bus-unit field, bits [28:20], equals 0x07F, the result is ok for any access kind. `real_addr` = {entry[3:0], ea[27:0]} and `res_prot` = 3'b111.
- R6: In any other direct-store segment, a fetch faults with code 0x10000000. A data access is granted read and, when the key is 1, also write, with `real_addr` equal to the effective address. A store whose key is 0 faults with status 0x0A000000.
- R7: A fetch from a segment with bit 31 clear and bit 28 set (no-execute) faults with code 0x10000000 without asking the walker. A load from the same segment is walked normally.
- R8: A walker response with `walk_rsp_found` low faults. A fetch gets code 0x40000000, a store gets status 0x42000000 and a load gets status 0x40000000.
- R9: Page permission follows key and the 2-bit protection code. With key 0, codes 0, 1 and 2 give read+write and code 3 gives read. With key 1, code 0 gives nothing, codes 1 and 3 give read and code 2 gives read+write. Execute is added whenever read is granted. A violation uses the R3 codes.
- R10: The key is segment bit 29 for a user-mode request and segment bit 30 for a supervisor request.
- R11: A granted walk gives `real_addr` = {`walk_rsp_rpn`, ea[11:0]}.
- R12: Every data fault loads `dar` with the effective address. When no data fault is reported, `dar` and `dsisr` read 0. When no instruction fault is reported, `ifault_code` reads 0. On a fault, `real_addr` and `res_prot` read 0.
- R13: `done` is high for exactly one cycle per request. All result outputs hold their values until the next completion. `req_ready` is high only while the sequencer is idle, which includes the cycle in which `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Sequencer idle, request will be taken |
| req_ea | input | 32 | Effective address |
| req_kind | input | 2 | 0 fetch, 1 load, 2 store, 3 load |
| req_user | input | 1 | 1 = user mode, 0 = supervisor |
| req_ien | input | 1 | Instruction translation enable |
| req_den | input | 1 | Data translation enable |
| seg_file | input | 512 | Sixteen 32-bit segment registers |
| blk_req_valid | output | 1 | Block matcher query |
| blk_req_ready | input | 1 | Block matcher takes the query |
| blk_req_ea | output | 32 | Address to match |
| blk_req_fetch | output | 1 | Query is for a fetch |
| blk_req_user | output | 1 | Query privilege |
| blk_rsp_valid | input | 1 | Block matcher answer present |
| blk_rsp_hit | input | 1 | Address falls in a block |
| blk_rsp_rpn | input | 20 | Real page number from the block |
| blk_rsp_prot | input | 3 | Block permission, read/write/execute |
| walk_req_valid | output | 1 | Table walk request |
| walk_req_ready | input | 1 | Walker takes the request |
| walk_req_vsid | output | 24 | Virtual segment id |
| walk_req_pidx | output | 16 | Page index within the segment |
| walk_rsp_valid | input | 1 | Walker answer present |
| walk_rsp_found | input | 1 | Matching entry exists |
| walk_rsp_rpn | input | 20 | Real page number of the entry |
| walk_rsp_pp | input | 2 | Entry protection code |
| done | output | 1 | One-cycle completion pulse |
| res_ok | output | 1 | Translation granted |
| real_addr | output | 32 | Translated real address |
| res_prot | output | 3 | Granted permission |
| ifault | output | 1 | Instruction fault |
| ifault_code | output | 32 | Instruction fault error code |
| dfault | output | 1 | Data fault |
| dar | output | 32 | Data fault address |
| dsisr | output | 32 | Data fault status word |

## Verification
Two events can land in the same cycle: the completion pulse of one access and the acceptance of the next, because `req_ready` is already high while `done` is high. The bench provokes this by raising a second request in exactly the `done` cycle of the first. At that instant it checks that the first result is still on the outputs. It then checks that the second access finishes with its own result, with no stale fault address or code carried over. Precedence collisions are covered the same way. The bench sets up accesses for which two sources would both apply, such as a block hit inside a no-execute segment, and checks which one decides the outcome and that the losing unit is never queried.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  localparam int EA_W  = 32;
  localparam int SEG_W = 32;
  localparam int PP_W  = 2;

  typedef enum logic [1:0] {
    AK_FETCH = 2'd0,
    AK_LOAD  = 2'd1,
    AK_STORE = 2'd2,
    AK_RSVD  = 2'd3
  } acc_kind_e;

  typedef enum logic [1:0] {
    FW_NONE   = 2'd0,
    FW_PROT   = 2'd1,
    FW_NOEXEC = 2'd2,
    FW_MISS   = 2'd3
  } fault_why_e;

  localparam logic [2:0] PRM_R = 3'b001;
  localparam logic [2:0] PRM_W = 3'b010;
  localparam logic [2:0] PRM_X = 3'b100;

  localparam logic [31:0] CODE_NOEXEC  = 32'h1000_0000;
  localparam logic [31:0] CODE_PROT_LD = 32'h0800_0000;
  localparam logic [31:0] CODE_PROT_ST = 32'h0A00_0000;
  localparam logic [31:0] CODE_MISS_LD = 32'h4000_0000;
  localparam logic [31:0] CODE_MISS_ST = 32'h4200_0000;

  localparam logic [8:0] DS_MEM_BUS = 9'h07F;

  // permission an access kind needs
  function automatic logic [2:0] need_of(acc_kind_e k);
    case (k)
      AK_FETCH: need_of = PRM_X;
      AK_STORE: need_of = PRM_W;
      default:  need_of = PRM_R;
    endcase
  endfunction

  // key + protection code to read/write/execute
  function automatic logic [2:0] page_prot(logic key, logic [PP_W-1:0] pp);
    logic rd;
    logic wr;
    if (!key) begin
      rd = 1'b1;
      wr = (pp != 2'd3);
    end else begin
      rd = (pp != 2'd0);
      wr = (pp == 2'd2);
    end
    page_prot = {rd, wr, rd};
  endfunction

  // fault reason + kind to the reported 32-bit word
  function automatic logic [31:0] fault_word(fault_why_e w, acc_kind_e k);
    logic st;
    st = (k == AK_STORE);
    case (w)
      FW_NOEXEC: fault_word = CODE_NOEXEC;
      FW_PROT:   fault_word = st ? CODE_PROT_ST : CODE_PROT_LD;
      FW_MISS:   fault_word = st ? CODE_MISS_ST : CODE_MISS_LD;
      default:   fault_word = 32'h0;
    endcase
  endfunction

endpackage

// File: rtl/xlat_seg_pick.sv
module xlat_seg_pick
  import xlat_pkg::*;
#(
  parameter int SEG_BITS = 4,
  parameter int VSID_W   = 24
) (
  input  logic [(SEG_W << SEG_BITS)-1:0] seg_file,
  input  logic [SEG_BITS-1:0]            sel,
  output logic                           ds,
  output logic                           key_sup,
  output logic                           key_usr,
  output logic                           nx,
  output logic [8:0]                     bus_id,
  output logic [3:0]                     hi_nib,
  output logic [VSID_W-1:0]              vsid
);
  localparam int NSEG = 1 << SEG_BITS;

  logic [SEG_W-1:0] seg_arr [NSEG];
  logic [SEG_W-1:0] ent;

  genvar g;
  generate
    for (g = 0; g < NSEG; g++) begin : g_unpack
      assign seg_arr[g] = seg_file[g*SEG_W +: SEG_W];
    end
  endgenerate

  assign ent     = seg_arr[sel];
  assign ds      = ent[31];
  assign key_sup = ent[30];
  assign key_usr = ent[29];
  assign nx      = ent[28];
  assign bus_id  = ent[28:20];
  assign hi_nib  = ent[3:0];
  assign vsid    = ent[VSID_W-1:0];

endmodule

// File: rtl/xlat_page_perm.sv
module xlat_page_perm
  import xlat_pkg::*;
(
  input  logic            user,
  input  logic            key_sup,
  input  logic            key_usr,
  input  logic [PP_W-1:0] pp,
  input  logic [2:0]      need,
  output logic            key,
  output logic [2:0]      pg_prot,
  output logic            pg_deny,
  output logic [2:0]      ds_prot,
  output logic            ds_deny
);
  assign key     = user ? key_usr : key_sup;
  assign pg_prot = page_prot(key, pp);
  assign pg_deny = |(need & ~pg_prot);
  assign ds_prot = key ? (PRM_R | PRM_W) : PRM_R;
  assign ds_deny = |(need & ~ds_prot);

  // R10 direct-store write permission tracks the selected key
  always_comb begin
    key_ds_chk: assert (ds_prot[1] == (user ? key_usr : key_sup));
  end

endmodule

// File: rtl/xlat_fault_enc.sv
module xlat_fault_enc
  import xlat_pkg::*;
(
  input  fault_why_e  why,
  input  acc_kind_e   kind,
  output logic        is_if,
  output logic        is_df,
  output logic [31:0] icode,
  output logic [31:0] dword
);
  logic [31:0] word;

  assign word  = fault_word(why, kind);
  assign is_if = (why != FW_NONE) && (kind == AK_FETCH);
  assign is_df = (why != FW_NONE) && (kind != AK_FETCH);
  assign icode = is_if ? word : 32'h0;
  assign dword = is_df ? word : 32'h0;

endmodule

// File: rtl/xlat_fault_seq.sv
module xlat_fault_seq
  import xlat_pkg::*;
#(
  parameter int PG_BITS   = 12,
  parameter int SEG_BITS  = 4,
  parameter int VSID_W    = 24,
  parameter bit HAS_BLOCK = 1'b1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           req_valid,
  output logic                           req_ready,
  input  logic [EA_W-1:0]                req_ea,
  input  logic [1:0]                     req_kind,
  input  logic                           req_user,
  input  logic                           req_ien,
  input  logic                           req_den,
  input  logic [(SEG_W << SEG_BITS)-1:0] seg_file,
  output logic                           blk_req_valid,
  input  logic                           blk_req_ready,
  output logic [EA_W-1:0]                blk_req_ea,
  output logic                           blk_req_fetch,
  output logic                           blk_req_user,
  input  logic                           blk_rsp_valid,
  input  logic                           blk_rsp_hit,
  input  logic [EA_W-PG_BITS-1:0]        blk_rsp_rpn,
  input  logic [2:0]                     blk_rsp_prot,
  output logic                           walk_req_valid,
  input  logic                           walk_req_ready,
  output logic [VSID_W-1:0]              walk_req_vsid,
  output logic [EA_W-SEG_BITS-PG_BITS-1:0] walk_req_pidx,
  input  logic                           walk_rsp_valid,
  input  logic                           walk_rsp_found,
  input  logic [EA_W-PG_BITS-1:0]        walk_rsp_rpn,
  input  logic [PP_W-1:0]                walk_rsp_pp,
  output logic                           done,
  output logic                           res_ok,
  output logic [EA_W-1:0]                real_addr,
  output logic [2:0]                     res_prot,
  output logic                           ifault,
  output logic [31:0]                    ifault_code,
  output logic                           dfault,
  output logic [EA_W-1:0]                dar,
  output logic [31:0]                    dsisr
);
  localparam int RPN_W  = EA_W - PG_BITS;
  localparam int PIDX_W = EA_W - SEG_BITS - PG_BITS;
  localparam int DS_LO  = EA_W - 4;

  typedef enum logic [2:0] {
    S_IDLE, S_EVAL, S_BLK_REQ, S_BLK_WAIT, S_SEG, S_WALK_REQ, S_WALK_WAIT
  } st_e;

  st_e          st, st_nx;
  logic [EA_W-1:0] cap_ea;
  acc_kind_e    cap_kind;
  logic         cap_user, cap_ien, cap_den;

  logic         xlat_off;
  logic [2:0]   need;
  logic         fin_valid, fin_ok;
  logic [EA_W-1:0] fin_addr;
  logic [2:0]   fin_prot;
  fault_why_e   fin_why;

  logic         sg_ds, sg_ks, sg_ku, sg_nx;
  logic [8:0]   sg_bus;
  logic [3:0]   sg_hi;
  logic [VSID_W-1:0] sg_vsid;

  logic         pm_key, pm_deny, ds_deny;
  logic [2:0]   pm_prot, ds_prot;

  logic         enc_if, enc_df;
  logic [31:0]  enc_icode, enc_dword;

  logic         blk_deny;
  logic         accept;

  assign accept   = req_valid && req_ready;
  assign req_ready = (st == S_IDLE);
  assign need     = need_of(cap_kind);
  assign xlat_off = (cap_kind == AK_FETCH) ? !cap_ien : !cap_den;
  assign blk_deny = |(need & ~blk_rsp_prot);

  xlat_seg_pick #(.SEG_BITS(SEG_BITS), .VSID_W(VSID_W)) u_seg (
    .seg_file (seg_file),
    .sel      (cap_ea[EA_W-1 -: SEG_BITS]),
    .ds       (sg_ds),
    .key_sup  (sg_ks),
    .key_usr  (sg_ku),
    .nx       (sg_nx),
    .bus_id   (sg_bus),
    .hi_nib   (sg_hi),
    .vsid     (sg_vsid)
  );

  xlat_page_perm u_perm (
    .user    (cap_user),
    .key_sup (sg_ks),
    .key_usr (sg_ku),
    .pp      (walk_rsp_pp),
    .need    (need),
    .key     (pm_key),
    .pg_prot (pm_prot),
    .pg_deny (pm_deny),
    .ds_prot (ds_prot),
    .ds_deny (ds_deny)
  );

  xlat_fault_enc u_enc (
    .why   (fin_why),
    .kind  (cap_kind),
    .is_if (enc_if),
    .is_df (enc_df),
    .icode (enc_icode),
    .dword (enc_dword)
  );

  // block matcher interface, present or tied off by parameter
  generate
    if (HAS_BLOCK) begin : g_blk
      assign blk_req_valid = (st == S_BLK_REQ);
      assign blk_req_ea    = cap_ea;
      assign blk_req_fetch = (cap_kind == AK_FETCH);
      assign blk_req_user  = cap_user;
    end else begin : g_noblk
      assign blk_req_valid = 1'b0;
      assign blk_req_ea    = '0;
      assign blk_req_fetch = 1'b0;
      assign blk_req_user  = 1'b0;
    end
  endgenerate

  assign walk_req_valid = (st == S_WALK_REQ);
  assign walk_req_vsid  = sg_vsid;
  assign walk_req_pidx  = cap_ea[EA_W-SEG_BITS-1:PG_BITS];

  // decision sequence
  always_comb begin
    st_nx     = st;
    fin_valid = 1'b0;
    fin_ok    = 1'b0;
    fin_addr  = cap_ea;
    fin_prot  = 3'b000;
    fin_why   = FW_NONE;
    case (st)
      S_IDLE: begin
        if (req_valid) st_nx = S_EVAL;
      end
      S_EVAL: begin
        if (xlat_off) begin
          fin_valid = 1'b1;
          fin_ok    = 1'b1;
          fin_prot  = PRM_R | PRM_W | PRM_X;
          st_nx     = S_IDLE;
        end else begin
          st_nx = HAS_BLOCK ? S_BLK_REQ : S_SEG;
        end
      end
      S_BLK_REQ: begin
        if (blk_req_ready) st_nx = S_BLK_WAIT;
      end
      S_BLK_WAIT: begin
        if (blk_rsp_valid) begin
          if (blk_rsp_hit) begin
            fin_valid = 1'b1;
            st_nx     = S_IDLE;
            if (blk_deny) begin
              fin_why = FW_PROT;
            end else begin
              fin_ok   = 1'b1;
              fin_addr = {blk_rsp_rpn, cap_ea[PG_BITS-1:0]};
              fin_prot = blk_rsp_prot;
            end
          end else begin
            st_nx = S_SEG;
          end
        end
      end
      S_SEG: begin
        if (sg_ds) begin
          fin_valid = 1'b1;
          st_nx     = S_IDLE;
          if (sg_bus == DS_MEM_BUS) begin
            fin_ok   = 1'b1;
            fin_addr = {sg_hi, cap_ea[DS_LO-1:0]};
            fin_prot = PRM_R | PRM_W | PRM_X;
          end else if (cap_kind == AK_FETCH) begin
            fin_why = FW_NOEXEC;
          end else if (ds_deny) begin
            fin_why = FW_PROT;
          end else begin
            fin_ok   = 1'b1;
            fin_prot = ds_prot;
          end
        end else if (cap_kind == AK_FETCH && sg_nx) begin
          fin_valid = 1'b1;
          fin_why   = FW_NOEXEC;
          st_nx     = S_IDLE;
        end else begin
          st_nx = S_WALK_REQ;
        end
      end
      S_WALK_REQ: begin
        if (walk_req_ready) st_nx = S_WALK_WAIT;
      end
      S_WALK_WAIT: begin
        if (walk_rsp_valid) begin
          fin_valid = 1'b1;
          st_nx     = S_IDLE;
          if (!walk_rsp_found) begin
            fin_why = FW_MISS;
          end else if (pm_deny) begin
            fin_why = FW_PROT;
          end else begin
            fin_ok   = 1'b1;
            fin_addr = {walk_rsp_rpn, cap_ea[PG_BITS-1:0]};
            fin_prot = pm_prot;
          end
        end
      end
      default: st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cap_ea   <= '0;
      cap_kind <= AK_LOAD;
      cap_user <= 1'b0;
      cap_ien  <= 1'b0;
      cap_den  <= 1'b0;
    end else begin
      st <= st_nx;
      if (accept) begin
        cap_ea   <= req_ea;
        cap_kind <= acc_kind_e'(req_kind);
        cap_user <= req_user;
        cap_ien  <= req_ien;
        cap_den  <= req_den;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done        <= 1'b0;
      res_ok      <= 1'b0;
      real_addr   <= '0;
      res_prot    <= 3'b000;
      ifault      <= 1'b0;
      ifault_code <= '0;
      dfault      <= 1'b0;
      dar         <= '0;
      dsisr       <= '0;
    end else begin
      done <= fin_valid;
      if (fin_valid) begin
        res_ok      <= fin_ok;
        real_addr   <= fin_ok ? fin_addr : '0;
        res_prot    <= fin_ok ? fin_prot : 3'b000;
        ifault      <= enc_if;
        ifault_code <= enc_icode;
        dfault      <= enc_df;
        dar         <= enc_df ? cap_ea : '0;
        dsisr       <= enc_dword;
      end
    end
  end

  // R13
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R13
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(real_addr) && $stable(dsisr) && $stable(ifault_code)
               && $stable(dar) && $stable(res_ok)));

  // R12
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($countones({res_ok, ifault, dfault}) == 1));

  // R12
  dar_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && dfault) |-> (dar == cap_ea));

  // R12
  fetch_no_dfault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cap_kind == AK_FETCH) |-> !dfault);

  // R1
  real_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_EVAL && xlat_off) |=> (done && res_ok && res_prot == 3'b111 && !blk_req_valid));

  // R2
  blk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_req_valid && !blk_req_ready) |=> blk_req_valid);

  // R11
  walk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_req_valid && !walk_req_ready) |=> walk_req_valid);

endmodule

// File: tb/xlat_fault_seq_test.sv
module xlat_fault_seq_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        req_valid = 1'b0, req_ready;
  logic [31:0] req_ea = '0;
  logic [1:0]  req_kind = '0;
  logic        req_user = 1'b0, req_ien = 1'b0, req_den = 1'b0;
  logic [511:0] segs = '0;
  logic        blk_req_valid, blk_req_fetch, blk_req_user;
  logic [31:0] blk_req_ea;
  logic        blk_rsp_valid = 1'b0;
  logic        bm_hit = 1'b0;
  logic [19:0] bm_rpn = '0;
  logic [2:0]  bm_prot = '0;
  logic        walk_req_valid;
  logic [23:0] walk_req_vsid;
  logic [15:0] walk_req_pidx;
  logic        walk_rsp_valid = 1'b0;
  logic        wk_found = 1'b0;
  logic [19:0] wk_rpn = '0;
  logic [1:0]  wk_pp = '0;
  logic        done, res_ok, ifault, dfault;
  logic [31:0] real_addr, ifault_code, dar, dsisr;
  logic [2:0]  res_prot;

  int blk_cnt = 0, walk_cnt = 0;
  logic [23:0] last_vsid = '0;
  logic [15:0] last_pidx = '0;
  int n_chk = 0, n_err = 0;

  xlat_fault_seq uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_ea(req_ea),
    .req_kind(req_kind), .req_user(req_user), .req_ien(req_ien), .req_den(req_den),
    .seg_file(segs),
    .blk_req_valid(blk_req_valid), .blk_req_ready(1'b1), .blk_req_ea(blk_req_ea),
    .blk_req_fetch(blk_req_fetch), .blk_req_user(blk_req_user),
    .blk_rsp_valid(blk_rsp_valid), .blk_rsp_hit(bm_hit), .blk_rsp_rpn(bm_rpn),
    .blk_rsp_prot(bm_prot),
    .walk_req_valid(walk_req_valid), .walk_req_ready(1'b1),
    .walk_req_vsid(walk_req_vsid), .walk_req_pidx(walk_req_pidx),
    .walk_rsp_valid(walk_rsp_valid), .walk_rsp_found(wk_found),
    .walk_rsp_rpn(wk_rpn), .walk_rsp_pp(wk_pp),
    .done(done), .res_ok(res_ok), .real_addr(real_addr), .res_prot(res_prot),
    .ifault(ifault), .ifault_code(ifault_code), .dfault(dfault),
    .dar(dar), .dsisr(dsisr)
  );

  // responder models: answer one cycle after the query
  always @(posedge clk) begin
    blk_rsp_valid  <= blk_req_valid;
    walk_rsp_valid <= walk_req_valid;
    if (blk_req_valid) blk_cnt <= blk_cnt + 1;
    if (walk_req_valid) begin
      walk_cnt  <= walk_cnt + 1;
      last_vsid <= walk_req_vsid;
      last_pidx <= walk_req_pidx;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_seg(input int idx, input logic [31:0] v);
    segs[idx*32 +: 32] = v;
  endtask

  task automatic wait_done();
    int k;
    k = 0;
    while (done !== 1'b1 && k < 50) begin
      @(negedge clk);
      k++;
    end
    if (done !== 1'b1) begin
      n_chk++; n_err++;
      $display("FAIL R13 done never seen actual=0 expected=1");
    end
  endtask

  task automatic issue(input logic [1:0] kind, input logic [31:0] ea,
                       input logic user, input logic ien, input logic den);
    req_kind = kind; req_ea = ea; req_user = user; req_ien = ien; req_den = den;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    wait_done();
  endtask

  task automatic expect_ok(input string tag, input logic [31:0] addr, input logic [2:0] prot);
    chk({tag, " ok"}, {31'd0, res_ok}, 32'd1);
    chk({tag, " addr"}, real_addr, addr);
    chk({tag, " prot"}, {29'd0, res_prot}, {29'd0, prot});
    chk({tag, " dsisr"}, dsisr, 32'h0);
    chk({tag, " icode"}, ifault_code, 32'h0);
  endtask

  task automatic expect_if(input string tag, input logic [31:0] code);
    chk({tag, " ifault"}, {31'd0, ifault}, 32'd1);
    chk({tag, " icode"}, ifault_code, code);
    chk({tag, " dar"}, dar, 32'h0);
  endtask

  task automatic expect_df(input string tag, input logic [31:0] ea, input logic [31:0] st);
    chk({tag, " dfault"}, {31'd0, dfault}, 32'd1);
    chk({tag, " dsisr"}, dsisr, st);
    chk({tag, " dar"}, dar, ea);
    chk({tag, " addr"}, real_addr, 32'h0);
  endtask

  task automatic t_reset();
    chk("R13 reset done", {31'd0, done}, 32'd0);
    chk("R13 reset ready", {31'd0, req_ready}, 32'd1);
    chk("R12 reset addr", real_addr, 32'h0);
  endtask

  task automatic t_real_mode();
    int b0;
    b0 = blk_cnt;
    issue(2'd0, 32'h1234_5678, 1'b0, 1'b0, 1'b1);
    expect_ok("R1 fetch real", 32'h1234_5678, 3'b111);
    issue(2'd2, 32'hDEAD_BEE0, 1'b1, 1'b1, 1'b0);
    expect_ok("R1 store real", 32'hDEAD_BEE0, 3'b111);
    chk("R1 no block query", blk_cnt - b0, 0);
  endtask

  task automatic t_block();
    int w0;
    w0 = walk_cnt;
    bm_hit = 1'b1; bm_rpn = 20'hABC12; bm_prot = 3'b001;
    issue(2'd1, 32'h5000_0ABC, 1'b0, 1'b1, 1'b1);
    expect_ok("R2 block load", 32'hABC1_2ABC, 3'b001);
    chk("R2 no walk", walk_cnt - w0, 0);
    issue(2'd2, 32'h5000_0100, 1'b0, 1'b1, 1'b1);
    expect_df("R3 block store deny", 32'h5000_0100, 32'h0A00_0000);
    issue(2'd0, 32'h5000_0200, 1'b0, 1'b1, 1'b1);
    expect_if("R3 block fetch deny", 32'h0800_0000);
    bm_prot = 3'b010;
    issue(2'd1, 32'h5000_0300, 1'b0, 1'b1, 1'b1);
    expect_df("R3 block load deny", 32'h5000_0300, 32'h0800_0000);
    // block hit wins over a no-execute segment
    set_seg(5, 32'h1000_0000); bm_prot = 3'b101;
    issue(2'd0, 32'h5000_0400, 1'b0, 1'b1, 1'b1);
    expect_ok("R2 block before segment", 32'hABC1_2400, 3'b101);
    bm_hit = 1'b0;
  endtask

  task automatic t_direct_store();
    set_seg(3, 32'h8000_0000 | (32'h07F << 20) | 32'h5);
    issue(2'd0, 32'h3123_4567, 1'b0, 1'b1, 1'b1);
    expect_ok("R5 ds memory fetch", 32'h5123_4567, 3'b111);
    issue(2'd2, 32'h3FFF_FFFF, 1'b1, 1'b1, 1'b1);
    expect_ok("R5 ds memory store", 32'h5FFF_FFFF, 3'b111);
    // other bus id, user key bit29 set, supervisor key bit30 clear
    set_seg(4, 32'h8000_0000 | (32'h010 << 20) | 32'h2000_0000);
    issue(2'd0, 32'h4000_0010, 1'b0, 1'b1, 1'b1);
    expect_if("R6 ds fetch", 32'h1000_0000);
    issue(2'd2, 32'h4000_0020, 1'b1, 1'b1, 1'b1);
    expect_ok("R10 R6 ds user store", 32'h4000_0020, 3'b011);
    issue(2'd2, 32'h4000_0030, 1'b0, 1'b1, 1'b1);
    expect_df("R10 R6 ds sup store", 32'h4000_0030, 32'h0A00_0000);
    issue(2'd1, 32'h4000_0040, 1'b0, 1'b1, 1'b1);
    expect_ok("R6 ds sup load", 32'h4000_0040, 3'b001);
  endtask

  task automatic t_noexec_and_walk();
    int w0;
    set_seg(6, 32'h1000_0000 | 32'h00_ABCD);
    wk_found = 1'b1; wk_rpn = 20'hABCDE; wk_pp = 2'd2;
    w0 = walk_cnt;
    issue(2'd0, 32'h6000_1000, 1'b0, 1'b1, 1'b1);
    expect_if("R7 nx fetch", 32'h1000_0000);
    chk("R7 no walk", walk_cnt - w0, 0);
    issue(2'd1, 32'h6765_4123, 1'b0, 1'b1, 1'b1);
    expect_ok("R11 R7 nx load walked", 32'hABCD_E123, 3'b111);
    chk("R4 vsid", {8'd0, last_vsid}, 32'h0000_ABCD);
    chk("R4 pidx", {16'd0, last_pidx}, 32'h0000_7654);
  endtask

  task automatic t_miss();
    set_seg(7, 32'h0012_3456);
    wk_found = 1'b0;
    issue(2'd1, 32'h7000_0004, 1'b0, 1'b1, 1'b1);
    expect_df("R8 miss load", 32'h7000_0004, 32'h4000_0000);
    issue(2'd2, 32'h7000_0008, 1'b0, 1'b1, 1'b1);
    expect_df("R8 miss store", 32'h7000_0008, 32'h4200_0000);
    issue(2'd0, 32'h7000_000C, 1'b0, 1'b1, 1'b1);
    expect_if("R8 miss fetch", 32'h4000_0000);
    wk_found = 1'b1;
  endtask

  task automatic t_perm();
    // seg 8: supervisor key 0, user key 1
    set_seg(8, 32'h2000_0042);
    wk_rpn = 20'h00111;
    wk_pp = 2'd0;
    issue(2'd1, 32'h8000_0010, 1'b1, 1'b1, 1'b1);
    expect_df("R9 key1 pp0 load", 32'h8000_0010, 32'h0800_0000);
    wk_pp = 2'd3;
    issue(2'd2, 32'h8000_0020, 1'b0, 1'b1, 1'b1);
    expect_df("R9 key0 pp3 store", 32'h8000_0020, 32'h0A00_0000);
    wk_pp = 2'd2;
    issue(2'd2, 32'h8000_0030, 1'b1, 1'b1, 1'b1);
    expect_ok("R9 key1 pp2 store", 32'h0011_1030, 3'b111);
    wk_pp = 2'd1;
    issue(2'd0, 32'h8000_0040, 1'b0, 1'b1, 1'b1);
    expect_ok("R9 key0 pp1 fetch", 32'h0011_1040, 3'b111);
    issue(2'd0, 32'h8000_0050, 1'b1, 1'b1, 1'b1);
    expect_ok("R9 key1 pp1 fetch", 32'h0011_1050, 3'b101);
    issue(2'd2, 32'h8000_0060, 1'b1, 1'b1, 1'b1);
    expect_df("R9 key1 pp1 store", 32'h8000_0060, 32'h0A00_0000);
  endtask

  task automatic t_back_to_back();
    // first: data fault; second request raised during its done cycle
    wk_found = 1'b0;
    req_kind = 2'd2; req_ea = 32'h7000_0100; req_user = 1'b0;
    req_ien = 1'b1; req_den = 1'b1; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    wait_done();
    chk("R13 ready during done", {31'd0, req_ready}, 32'd1);
    chk("R12 first dar held", dar, 32'h7000_0100);
    req_kind = 2'd1; req_ea = 32'hA000_0ABC; req_user = 1'b0;
    req_ien = 1'b1; req_den = 1'b0; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R13 done one cycle", {31'd0, done}, 32'd0);
    chk("R13 first status held", dsisr, 32'h4200_0000);
    wait_done();
    expect_ok("R12 second after fault", 32'hA000_0ABC, 3'b111);
    chk("R12 dar cleared", dar, 32'h0);
    repeat (5) @(negedge clk);
    chk("R13 hold addr", real_addr, 32'hA000_0ABC);
    chk("R13 no extra done", {31'd0, done}, 32'd0);
    wk_found = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_real_mode();
    t_block();
    t_direct_store();
    t_noexec_and_walk();
    t_miss();
    t_perm();
    t_back_to_back();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

endmodule